// File: doc/BRIEF.md
# Multi-Mode DMA Transfer Channel

A single DMA channel that copies a run of data units from a source region to a destination region. Software programs a source address, a destination address, a unit count and a control word through a small register port, then sets the enable bit. The channel moves each unit as a bus-master read of the source followed by a write to the destination. It uses a request/grant handshake and completes each access when the slave raises `m_ready`.

Each side has its own address policy: it can step up, step down or stay put. The unit width is 1, 2, 4 or 16 bytes. A 16-byte unit is carried as four 32-bit beats at consecutive word addresses. After a 16-byte unit both addresses always advance by 16, whatever their policy. The bus can be held in one of two ways. In cycle-steal mode the request is dropped after every single access. In burst mode the request is held from the first access until the whole transfer is finished. A completion flag, an error flag and an interrupt line report the outcome.

Register map (index on `cfg_widx`/`cfg_ridx`): 0 source address, 1 destination address, 2 unit count, 3 control. Control bits: [0] enable, [1] done (write 1 to clear), [2] error (write 1 to clear), [3] interrupt enable, [5:4] source policy, [7:6] destination policy (0 or 3 fixed, 1 up, 2 down), [9:8] unit size (0 byte, 1 16-bit, 2 32-bit, 3 16-byte), [10] burst hold. Bus data is right-justified. `m_size` codes the access width: 0 byte, 1 16-bit, 2 32-bit.

Top module: `dma_xfer_chan`

## Requirements
- R1: After reset all four registers read 0, `irq` is 0 and `m_req` is 0.
- R2: After a transfer of N units, each address register holds its start value plus N×width (policy up), minus N×width (policy down) or unchanged (fixed). This applies to widths 1, 2 and 4.
- R3: For widths 1, 2 and 4, every unit reads `width` bytes from the current source address, with `m_size` 0, 1 or 2. It then writes those bytes to the current destination address, so the destination region ends up matching the source.
- R4: A 16-byte unit makes four 32-bit reads at source+0, +4, +8 and +12, then four 32-bit writes at the matching destination offsets. Both addresses then advance by 16 regardless of their policy bits.
- R5: In cycle-steal mode `m_req` falls in the cycle after every completed access. Every access therefore starts with its own request.
- R6: In burst mode `m_req` rises once per transfer and stays high until the last access of the last unit has completed.
- R7: The count drops by one per finished unit. When it reaches zero, done is set and enable is cleared. Starting with a count of 0 sets done at once, with no bus access.
- R8: A start with a source or destination address that is not a multiple of the unit width (16 for the 16-byte mode) makes no bus access. It sets the error flag, clears enable and leaves the count unchanged.
- R9: `irq` equals done AND interrupt enable.
- R10: Writing 1 to the done or error bit clears it. A channel with done or error still set does not start when enable is written to 1.
- R11: Register writes made while a transfer is in progress are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_widx | input | 2 | Register write index |
| cfg_wdata | input | 32 | Register write data |
| cfg_ridx | input | 2 | Register read index |
| cfg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Completion interrupt |
| m_req | output | 1 | Bus request |
| m_gnt | input | 1 | Bus grant |
| m_valid | output | 1 | Access in progress |
| m_we | output | 1 | Access is a write |
| m_size | output | 2 | Access width code |
| m_addr | output | AW (32) | Access byte address |
| m_wdata | output | 32 | Write data, right-justified |
| m_rdata | input | 32 | Read data, right-justified |
| m_ready | input | 1 | Access completes this cycle |

## Verification
A register write lands at the clock edge that samples it. The sequencer reacts one edge later: it either raises `m_req` or sets the error or done flag. The bench therefore reads the flags a few cycles after the enable write, at a falling edge. The done flag, the count and the final addresses all change at the edge where the last write beat completes. The bench polls the control register at falling edges and compares everything only after done or error is seen. The bus model drives `m_gnt`, `m_ready` and read data at falling edges, applies writes in the cycle it raises `m_ready`, and counts accesses and request rises as they happen. These counts are then compared with the counts expected for the programmed mode.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

    typedef enum logic [1:0] {
        AM_FIXED  = 2'd0,
        AM_UP     = 2'd1,
        AM_DOWN   = 2'd2,
        AM_HOLD   = 2'd3
    } amode_e;

    typedef enum logic [1:0] {
        US_BYTE = 2'd0,
        US_HALF = 2'd1,
        US_WORD = 2'd2,
        US_QUAD = 2'd3
    } usize_e;

    typedef struct packed {
        logic   burst;
        usize_e usize;
        amode_e dmode;
        amode_e smode;
        logic   irq_en;
        logic   err;
        logic   done;
        logic   en;
    } ctrl_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARB  = 2'd1,
        ST_XFER = 2'd2,
        ST_REL  = 2'd3
    } seq_e;

    localparam logic [1:0] IDX_SRC  = 2'd0;
    localparam logic [1:0] IDX_DST  = 2'd1;
    localparam logic [1:0] IDX_CNT  = 2'd2;
    localparam logic [1:0] IDX_CTRL = 2'd3;

    localparam int QUAD_BEATS = 4;

    function automatic logic [4:0] unit_bytes(input usize_e us);
        case (us)
            US_BYTE: unit_bytes = 5'd1;
            US_HALF: unit_bytes = 5'd2;
            US_WORD: unit_bytes = 5'd4;
            default: unit_bytes = 5'd16;
        endcase
    endfunction

    function automatic logic [3:0] align_mask(input usize_e us);
        case (us)
            US_BYTE: align_mask = 4'h0;
            US_HALF: align_mask = 4'h1;
            US_WORD: align_mask = 4'h3;
            default: align_mask = 4'hF;
        endcase
    endfunction

endpackage

// File: rtl/dma_chan_agen.sv
module dma_chan_agen
    import dma_chan_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-1:0] base,
    input  amode_e        mode,
    input  usize_e        usize,
    input  logic [1:0]    beat,
    output logic [AW-1:0] beat_addr,
    output logic [AW-1:0] next_addr
);
    logic [AW-1:0] step;

    always_comb begin
        step = AW'(unit_bytes(usize));
        if (usize == US_QUAD) begin
            beat_addr = base + AW'({beat, 2'b00});
            next_addr = base + AW'(16);
        end else begin
            beat_addr = base;
            case (mode)
                AM_UP:   next_addr = base + step;
                AM_DOWN: next_addr = base - step;
                default: next_addr = base;
            endcase
        end
    end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
    import dma_chan_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [1:0]    wr_idx,
    input  logic [31:0]   wr_data,
    input  logic [1:0]    rd_idx,
    output logic [31:0]   rd_data,
    input  logic          busy,
    input  logic [AW-1:0] src_nxt,
    input  logic [AW-1:0] dst_nxt,
    input  logic          unit_done,
    input  logic          set_done,
    input  logic          set_err,
    output logic [AW-1:0] src,
    output logic [AW-1:0] dst,
    output logic [CW-1:0] cnt,
    output ctrl_t         ctrl
);
    logic last_unit;
    assign last_unit = unit_done && (cnt == CW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            src  <= '0;
            dst  <= '0;
            cnt  <= '0;
            ctrl <= '0;
        end else begin
            if (wr_en && !busy) begin
                case (wr_idx)
                    IDX_SRC: src <= wr_data[AW-1:0];
                    IDX_DST: dst <= wr_data[AW-1:0];
                    IDX_CNT: cnt <= wr_data[CW-1:0];
                    default: begin
                        ctrl.en     <= wr_data[0];
                        ctrl.done   <= ctrl.done & ~wr_data[1];
                        ctrl.err    <= ctrl.err & ~wr_data[2];
                        ctrl.irq_en <= wr_data[3];
                        ctrl.smode  <= amode_e'(wr_data[5:4]);
                        ctrl.dmode  <= amode_e'(wr_data[7:6]);
                        ctrl.usize  <= usize_e'(wr_data[9:8]);
                        ctrl.burst  <= wr_data[10];
                    end
                endcase
            end
            if (unit_done) begin
                src <= src_nxt;
                dst <= dst_nxt;
                cnt <= cnt - CW'(1);
            end
            if (last_unit || set_done) begin
                ctrl.done <= 1'b1;
                ctrl.en   <= 1'b0;
            end
            if (set_err) begin
                ctrl.err <= 1'b1;
                ctrl.en  <= 1'b0;
            end
        end
    end

    always_comb begin
        case (rd_idx)
            IDX_SRC: rd_data = 32'(src);
            IDX_DST: rd_data = 32'(dst);
            IDX_CNT: rd_data = 32'(cnt);
            default: rd_data = 32'(ctrl);
        endcase
    end

    // R8: an alignment fault leaves the count where it was
    p_err_keeps_cnt_r8: assert property (@(posedge clk) disable iff (rst)
        set_err |=> cnt == $past(cnt));

    // R7: done only ever rises with the count at zero
    p_done_at_zero_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(ctrl.done) |-> cnt == '0);

    // R4: a 16-byte unit advances the source by exactly 16
    p_quad_step_r4: assert property (@(posedge clk) disable iff (rst)
        (unit_done && ctrl.usize == US_QUAD) |=> src == $past(src) + AW'(16));
endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
    import dma_chan_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  ctrl_t         ctrl,
    input  logic [CW-1:0] cnt,
    input  logic [AW-1:0] src,
    input  logic [AW-1:0] dst,
    input  logic [AW-1:0] src_beat,
    input  logic [AW-1:0] dst_beat,
    input  logic          m_gnt,
    input  logic          m_ready,
    input  logic [31:0]   m_rdata,
    output logic          m_req,
    output logic          m_valid,
    output logic          m_we,
    output logic [1:0]    m_size,
    output logic [AW-1:0] m_addr,
    output logic [31:0]   m_wdata,
    output logic [1:0]    beat,
    output logic          busy,
    output logic          unit_done,
    output logic          set_done,
    output logic          set_err
);
    seq_e        state;
    logic        phase_wr;
    logic [31:0] dbuf [QUAD_BEATS];
    logic        start, misalign, last_beat, quad, done_xfer;
    logic [3:0]  amask;

    assign quad      = (ctrl.usize == US_QUAD);
    assign amask     = align_mask(ctrl.usize);
    assign misalign  = |(src[3:0] & amask) || |(dst[3:0] & amask);
    assign start     = (state == ST_IDLE) && ctrl.en && !ctrl.done && !ctrl.err;
    assign last_beat = !quad || (beat == 2'd3);

    always_comb begin
        set_done  = start && (cnt == '0);
        set_err   = start && (cnt != '0) && misalign;
        m_req     = (state == ST_ARB) || (state == ST_XFER);
        m_valid   = (state == ST_XFER);
        m_we      = phase_wr;
        m_addr    = phase_wr ? dst_beat : src_beat;
        m_wdata   = dbuf[beat];
        m_size    = quad ? 2'(US_WORD) : 2'(ctrl.usize);
        unit_done = m_valid && m_ready && phase_wr && last_beat;
        done_xfer = unit_done && (cnt == CW'(1));
        busy      = (state != ST_IDLE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            phase_wr <= 1'b0;
            beat     <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    phase_wr <= 1'b0;
                    beat     <= '0;
                    if (start && cnt != '0 && !misalign) state <= ST_ARB;
                end
                ST_ARB: if (m_gnt) state <= ST_XFER;
                ST_XFER: if (m_ready) begin
                    if (last_beat) begin
                        beat     <= '0;
                        phase_wr <= ~phase_wr;
                    end else begin
                        beat <= beat + 2'd1;
                    end
                    if (done_xfer)        state <= ST_IDLE;
                    else if (!ctrl.burst) state <= ST_REL;
                end
                default: state <= ST_ARB;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (state == ST_XFER && m_ready && !phase_wr) dbuf[beat] <= m_rdata;
    end

    // R5: cycle-steal gives the bus back right after every access
    p_steal_release_r5: assert property (@(posedge clk) disable iff (rst)
        (m_valid && m_ready && !ctrl.burst) |=> !m_req);

    // R6: burst keeps driving accesses until the transfer ends
    p_burst_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (m_valid && m_ready && ctrl.burst && !done_xfer) |=> (m_req && m_valid));

    // R3: every access on the bus is aligned to its width
    p_aligned_access_r3: assert property (@(posedge clk) disable iff (rst)
        m_valid |-> ((m_size == 2'd2 && m_addr[1:0] == 2'b00) ||
                     (m_size == 2'd1 && m_addr[0] == 1'b0) ||
                     (m_size == 2'd0)));

    // R8: a rejected start never reaches the bus
    p_fault_no_req_r8: assert property (@(posedge clk) disable iff (rst)
        set_err |=> !m_req);
endmodule

// File: rtl/dma_xfer_chan.sv
module dma_xfer_chan
    import dma_chan_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_widx,
    input  logic [31:0]   cfg_wdata,
    input  logic [1:0]    cfg_ridx,
    output logic [31:0]   cfg_rdata,
    output logic          irq,
    output logic          m_req,
    input  logic          m_gnt,
    output logic          m_valid,
    output logic          m_we,
    output logic [1:0]    m_size,
    output logic [AW-1:0] m_addr,
    output logic [31:0]   m_wdata,
    input  logic [31:0]   m_rdata,
    input  logic          m_ready
);
    logic [AW-1:0] src, dst, src_beat, dst_beat, src_nxt, dst_nxt;
    logic [CW-1:0] cnt;
    ctrl_t         ctrl;
    logic [1:0]    beat;
    logic          busy, unit_done, set_done, set_err;

    dma_chan_regs #(.AW(AW), .CW(CW)) regs_i (
        .clk(clk), .rst(rst),
        .wr_en(cfg_we), .wr_idx(cfg_widx), .wr_data(cfg_wdata),
        .rd_idx(cfg_ridx), .rd_data(cfg_rdata),
        .busy(busy), .src_nxt(src_nxt), .dst_nxt(dst_nxt),
        .unit_done(unit_done), .set_done(set_done), .set_err(set_err),
        .src(src), .dst(dst), .cnt(cnt), .ctrl(ctrl)
    );

    dma_chan_agen #(.AW(AW)) src_gen_i (
        .base(src), .mode(ctrl.smode), .usize(ctrl.usize), .beat(beat),
        .beat_addr(src_beat), .next_addr(src_nxt)
    );

    dma_chan_agen #(.AW(AW)) dst_gen_i (
        .base(dst), .mode(ctrl.dmode), .usize(ctrl.usize), .beat(beat),
        .beat_addr(dst_beat), .next_addr(dst_nxt)
    );

    dma_chan_seq #(.AW(AW), .CW(CW)) seq_i (
        .clk(clk), .rst(rst), .ctrl(ctrl), .cnt(cnt),
        .src(src), .dst(dst), .src_beat(src_beat), .dst_beat(dst_beat),
        .m_gnt(m_gnt), .m_ready(m_ready), .m_rdata(m_rdata),
        .m_req(m_req), .m_valid(m_valid), .m_we(m_we), .m_size(m_size),
        .m_addr(m_addr), .m_wdata(m_wdata), .beat(beat), .busy(busy),
        .unit_done(unit_done), .set_done(set_done), .set_err(set_err)
    );

    assign irq = ctrl.done && ctrl.irq_en;

    // R9: interrupt follows the done flag gated by its enable
    p_irq_needs_done_r9: assert property (@(posedge clk) disable iff (rst)
        irq |-> (cfg_ridx != 2'd3 || cfg_rdata[1]));
endmodule

// File: tb/dma_xfer_chan_tb_top.sv
module dma_xfer_chan_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_widx = '0;
    logic [31:0] cfg_wdata = '0;
    logic [1:0]  cfg_ridx = '0;
    logic [31:0] cfg_rdata;
    logic        irq, m_req, m_valid, m_we;
    logic        m_gnt = 1'b0;
    logic        m_ready = 1'b0;
    logic [1:0]  m_size;
    logic [31:0] m_addr, m_wdata;
    logic [31:0] m_rdata = '0;

    int n_chk = 0;
    int n_fail = 0;
    int n_acc = 0;
    int n_rise = 0;
    logic req_q = 1'b0;

    logic [7:0] mem  [0:1023];
    logic [7:0] refm [0:1023];

    always #10 clk = ~clk;

    dma_xfer_chan dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_widx(cfg_widx),
        .cfg_wdata(cfg_wdata), .cfg_ridx(cfg_ridx), .cfg_rdata(cfg_rdata),
        .irq(irq), .m_req(m_req), .m_gnt(m_gnt), .m_valid(m_valid),
        .m_we(m_we), .m_size(m_size), .m_addr(m_addr), .m_wdata(m_wdata),
        .m_rdata(m_rdata), .m_ready(m_ready)
    );

    // bus slave model, driven away from the active edge
    always @(negedge clk) begin
        if (rst) begin
            m_gnt = 1'b0; m_ready = 1'b0; req_q = 1'b0;
        end else begin
            if (m_req && !req_q) n_rise++;
            req_q = m_req;
            if (m_ready) m_ready = 1'b0;
            else if (m_valid && ($urandom % 2 == 0)) begin
                m_ready = 1'b1;
                n_acc++;
                if (m_we) bus_write(m_addr[9:0], m_size, m_wdata);
                else      m_rdata = bus_read(m_addr[9:0], m_size);
            end
            m_gnt = m_req && (m_gnt || ($urandom % 3 == 0));
        end
    end

    function automatic logic [31:0] bus_read(input logic [9:0] a, input logic [1:0] sz);
        case (sz)
            2'd0:    return {24'd0, mem[a]};
            2'd1:    return {16'd0, mem[a], mem[a+10'd1]};
            default: return {mem[a], mem[a+10'd1], mem[a+10'd2], mem[a+10'd3]};
        endcase
    endfunction

    task automatic bus_write(input logic [9:0] a, input logic [1:0] sz, input logic [31:0] d);
        case (sz)
            2'd0: mem[a] = d[7:0];
            2'd1: begin mem[a] = d[15:8]; mem[a+10'd1] = d[7:0]; end
            default: begin
                mem[a] = d[31:24]; mem[a+10'd1] = d[23:16];
                mem[a+10'd2] = d[15:8]; mem[a+10'd3] = d[7:0];
            end
        endcase
    endtask

    function automatic int nbytes(input int sz);
        return (sz == 3) ? 16 : (1 << sz);
    endfunction

    function automatic logic [31:0] exp_next(input logic [31:0] a, input int md, input int sz);
        if (sz == 3) return a + 32'd16;
        if (md == 1) return a + 32'(nbytes(sz));
        if (md == 2) return a - 32'(nbytes(sz));
        return a;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] idx, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_widx = idx; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] idx, output logic [31:0] d);
        cfg_ridx = idx;
        #1;
        d = cfg_rdata;
    endtask

    function automatic logic [31:0] mk_ctrl(input int sm, input int dm, input int sz,
                                            input bit burst, input bit ie);
        return 32'h1 | (32'(ie) << 3) | (32'(sm) << 4) | (32'(dm) << 6) |
               (32'(sz) << 8) | (32'(burst) << 10);
    endfunction

    task automatic wait_end();
        logic [31:0] c;
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            rd(2'd3, c);
            if (c[1] || c[2]) return;
        end
        chk("R7 transfer end", 32'hDEAD, 32'h0);
    endtask

    task automatic run_case(input logic [31:0] s, input logic [31:0] d, input int n,
                            input int sm, input int dm, input int sz,
                            input bit burst, input bit ie, input bit poke);
        logic [31:0] c, es, ed;
        int acc0, rise0, units_acc, mism;
        for (int i = 0; i < 1024; i++) refm[i] = mem[i];
        es = s; ed = d;
        for (int u = 0; u < n; u++) begin
            for (int b = 0; b < nbytes(sz); b++)
                refm[(ed + 32'(b)) & 32'h3FF] = refm[(es + 32'(b)) & 32'h3FF];
            es = exp_next(es, sm, sz);
            ed = exp_next(ed, dm, sz);
        end
        wr(2'd0, s); wr(2'd1, d); wr(2'd2, 32'(n));
        acc0 = n_acc; rise0 = n_rise;
        wr(2'd3, mk_ctrl(sm, dm, sz, burst, ie));
        if (poke) begin
            repeat (3) @(negedge clk);
            wr(2'd0, 32'h0000_0FF0); // R11: must be dropped
        end
        wait_end();
        units_acc = 2 * n * ((sz == 3) ? 4 : 1);
        mism = 0;
        for (int i = 0; i < 1024; i++) if (mem[i] !== refm[i]) mism++;
        chk(sz == 3 ? "R4 quad data" : "R3 unit data", 32'(mism), 32'd0);
        chk(sz == 3 ? "R4 access count" : "R3 access count", 32'(n_acc - acc0), 32'(units_acc));
        chk(burst ? "R6 request rises" : "R5 request rises", 32'(n_rise - rise0),
            burst ? 32'd1 : 32'(units_acc));
        rd(2'd0, c); chk(poke ? "R11 src after busy write" : "R2 final src", c, es);
        rd(2'd1, c); chk("R2 final dst", c, ed);
        rd(2'd2, c); chk("R7 count zero", c, 32'd0);
        rd(2'd3, c); chk("R7 done set enable clear", {30'd0, c[1], c[0]}, 32'h2);
        chk("R9 irq", 32'(irq), 32'(ie));
        wr(2'd3, 32'h2); // R10: clear done
        rd(2'd3, c); chk("R10 done cleared", 32'(c[1]), 32'd0);
        chk("R9 irq after clear", 32'(irq), 32'd0);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R7 watchdog act=hung exp=finished");
        finish_run();
    end

    initial begin
        logic [31:0] c;
        int acc0, rise0;
        void'($urandom(32'h5EED_0D3A));
        for (int i = 0; i < 1024; i++) mem[i] = 8'($urandom);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        for (int r = 0; r < 4; r++) begin
            rd(2'(r), c);
            chk("R1 reset register", c, 32'd0);
        end
        chk("R1 reset irq", 32'(irq), 32'd0);
        chk("R1 reset request", 32'(m_req), 32'd0);

        // directed: each width, each policy, both hold modes
        run_case(32'd200, 32'd700, 5, 1, 1, 0, 1'b0, 1'b1, 1'b0);
        run_case(32'd300, 32'd800, 4, 2, 1, 1, 1'b1, 1'b0, 1'b0);
        run_case(32'd256, 32'd768, 3, 0, 2, 2, 1'b0, 1'b1, 1'b0);
        run_case(32'd128, 32'd640, 3, 2, 0, 3, 1'b1, 1'b1, 1'b0); // R4 forced +16
        run_case(32'd144, 32'd656, 2, 0, 3, 3, 1'b0, 1'b0, 1'b0);
        run_case(32'd160, 32'd672, 6, 1, 1, 2, 1'b1, 1'b0, 1'b1); // R11 poke

        // R7 zero count
        wr(2'd2, 32'd0);
        acc0 = n_acc; rise0 = n_rise;
        wr(2'd3, mk_ctrl(1, 1, 2, 1'b0, 1'b1));
        repeat (3) @(negedge clk);
        rd(2'd3, c);
        chk("R7 zero count done", {30'd0, c[1], c[0]}, 32'h2);
        chk("R7 zero count no access", 32'(n_rise - rise0), 32'd0);

        // R10 no restart while done still set
        wr(2'd2, 32'd2);
        wr(2'd3, mk_ctrl(1, 1, 2, 1'b0, 1'b1) & ~32'h2);
        repeat (4) @(negedge clk);
        chk("R10 no restart with done", 32'(n_rise - rise0), 32'd0);
        wr(2'd3, 32'h2);

        // R8 misaligned source, then destination
        wr(2'd0, 32'd130); wr(2'd1, 32'd640); wr(2'd2, 32'd7);
        wr(2'd3, mk_ctrl(1, 1, 2, 1'b0, 1'b1));
        repeat (3) @(negedge clk);
        rd(2'd3, c);
        chk("R8 error set enable clear", {29'd0, c[2], c[1], c[0]}, 32'h4);
        rd(2'd2, c); chk("R8 count kept", c, 32'd7);
        chk("R8 no bus access", 32'(n_rise - rise0), 32'd0);
        chk("R9 no irq on error", 32'(irq), 32'd0);
        wr(2'd3, 32'h1); // R10: enable without clearing error
        repeat (3) @(negedge clk);
        chk("R10 no restart with error", 32'(n_rise - rise0), 32'd0);
        wr(2'd3, 32'h4);
        rd(2'd3, c); chk("R10 error cleared", 32'(c[2]), 32'd0);
        wr(2'd0, 32'd128); wr(2'd1, 32'd648);
        wr(2'd3, mk_ctrl(1, 1, 3, 1'b1, 1'b0));
        repeat (3) @(negedge clk);
        rd(2'd3, c); chk("R8 quad dst misaligned", 32'(c[2]), 32'd1);
        wr(2'd3, 32'h4);

        // random mix
        for (int k = 0; k < 40; k++) begin
            int sz, n;
            logic [31:0] s, d, msk;
            sz = int'($urandom % 4);
            n = 1 + int'($urandom % 8);
            msk = 32'(nbytes(sz) - 1);
            s = (32'd128 + ($urandom % 256)) & ~msk;
            d = (32'd640 + ($urandom % 256)) & ~msk;
            run_case(s, d, n, int'($urandom % 4), int'($urandom % 4), sz,
                     1'($urandom), 1'($urandom), 1'b0);
        end
        finish_run();
    end
endmodule